// File: doc/BRIEF.md
# Streaming 7x7 Convolution Engine

The engine takes a single-channel image as a stream, one signed fixed-point pixel per accepted transfer in raster order, and slides a 7x7 kernel across it with unit stride and no border padding. An input frame of IMG_H rows by IMG_W columns therefore yields (IMG_H-6) x (IMG_W-6) output positions. Several kernels (NK, ten by default) share one window, so every output transfer carries one result per kernel for the same spatial position. Each result is the bias plus the 49 pixel-by-coefficient products, scaled down by a fixed shift, clamped at zero and saturated to the output width.

Six line buffers of one row each plus a 7x7 register window hold only the pixels needed for the next position. One pixel enters per accepted transfer and the oldest leaves, so results start to flow once six full rows and seven pixels of the seventh row have arrived, well before the frame ends. A downstream layer can therefore run at the same time. Coefficients and biases are loaded through a plain write port into internal registers between frames.

Both streams use valid/ready. A transfer happens on a rising edge where valid and ready are both high. While an output is offered and not taken, the output holds still and the input is refused. Nothing else stalls the input, and a low input valid inserts a bubble without disturbing the window.

Top module: `stream_conv_engine`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: Every frame yields exactly (IMG_H-6)*(IMG_W-6) outputs, in raster order of the output grid, and the position counters restart on the pixel after the last one of a frame.
- R3: The value for output position (y,x) of kernel n is bias(n) + sum over j,k in 0..6 of pixel(y+j, x+k) * coef(n, j*7+k). On the write port, tap index j*7+k selects a coefficient, where j is the row offset and k is the column offset. Tap index 49 selects the bias. Coefficients take the low COEF_W bits of cfg_data and the bias takes all BIAS_W bits.
- R4: The sum is arithmetically shifted right by FRAC_SH before it is output.
- R5: A negative sum gives zero on that lane.
- R6: A scaled result above 2^(OUT_W-1)-1 is output as 2^(OUT_W-1)-1.
- R7: Kernel n's result occupies out_data bits [n*OUT_W +: OUT_W].
- R8: out_last is high only with out_valid, and it is high exactly on the output for the last position of a frame (bottom-right).
- R9: While out_valid is high and out_ready low, out_valid, out_data and out_last stay unchanged on the next cycle.
- R10: in_ready is low when an output is waiting and out_ready is low. It is high whenever out_valid is low.
- R11: Input bubbles and output back-pressure in any pattern leave the output sequence unchanged: no pixel is lost or counted twice.
- R12: The first output of a frame is offered before the frame's last pixel has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel is valid |
| in_ready | output | 1 | Engine accepts a pixel |
| in_pixel | input | DATA_W | Signed pixel, raster order |
| out_valid | output | 1 | Output position is valid |
| out_ready | input | 1 | Consumer takes the output |
| out_data | output | NK*OUT_W | One non-negative result per kernel, kernel n at [n*OUT_W +: OUT_W] |
| out_last | output | 1 | Marks the final position of a frame |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_kern | input | idx_w(NK) | Kernel selected for the write |
| cfg_tap | input | idx_w(50) | Tap 0..48 or bias (49) |
| cfg_data | input | BIAS_W | Write value (low COEF_W bits for a tap) |

## Verification
The assertions watch the handshake every cycle. They check that a stalled output keeps its valid, data and last flag, that input is refused exactly while an output waits, that out_last never appears without out_valid, and that no lane ever shows a negative value. The arithmetic results, raster order, output count, frame boundaries, saturation, lane layout and early start depend on whole frames of data. Only the bench's scenarios can show these, by comparing every output against a behavioural model under random images, random coefficients, extreme coefficients and random bubbles and stalls.

// File: rtl/conv_pkg.sv
package conv_pkg;

  // Width of an index able to address n items (at least one bit).
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Accumulator width that holds bias plus taps products without overflow.
  function automatic int acc_w(input int dw, input int cw, input int bw, input int taps);
    int s;
    s = dw + cw + $clog2(taps) + 1;
    return (s > bw) ? s + 1 : bw + 1;
  endfunction

endpackage

// File: rtl/cv_window.sv
module cv_window #(
  parameter int DATA_W = 8,
  parameter int IMG_W  = 28,
  parameter int IMG_H  = 28,
  parameter int KS     = 7
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             step,
  input  logic [DATA_W-1:0]                pix,
  output logic [KS*KS-1:0][DATA_W-1:0]     win,
  output logic                             pos_ok,
  output logic                             pos_last
);
  localparam int LB_N = KS - 1;
  localparam int CW   = conv_pkg::idx_w(IMG_W);
  localparam int RW   = conv_pkg::idx_w(IMG_H);
  localparam logic [CW-1:0] COL_MAX = CW'(IMG_W - 1);
  localparam logic [RW-1:0] ROW_MAX = RW'(IMG_H - 1);
  localparam logic [CW-1:0] COL_MIN = CW'(KS - 1);
  localparam logic [RW-1:0] ROW_MIN = RW'(KS - 1);

  logic [CW-1:0] col_cnt;
  logic [RW-1:0] row_cnt;
  logic [DATA_W-1:0] lbuf [LB_N][IMG_W];
  logic [DATA_W-1:0] wreg [KS][KS];
  logic [KS-1:0][DATA_W-1:0] colv;

  // Column entering the window: oldest row at index 0, new pixel on top.
  always_comb begin
    colv[KS-1] = pix;
    for (int i = 0; i < LB_N; i++) colv[KS-2-i] = lbuf[i][col_cnt];
  end

  always_ff @(posedge clk) begin
    if (step) begin
      lbuf[0][col_cnt] <= pix;
      for (int i = 1; i < LB_N; i++) lbuf[i][col_cnt] <= lbuf[i-1][col_cnt];
    end
  end

  genvar gj;
  generate
    for (gj = 0; gj < KS; gj++) begin : g_row
      always_ff @(posedge clk) begin
        if (step) begin
          for (int k = 0; k < KS - 1; k++) wreg[gj][k] <= wreg[gj][k+1];
          wreg[gj][KS-1] <= colv[gj];
        end
      end
      for (genvar gk = 0; gk < KS; gk++) begin : g_col
        assign win[gj*KS + gk] = wreg[gj][gk];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_cnt <= '0;
      row_cnt <= '0;
    end else if (step) begin
      if (col_cnt == COL_MAX) begin
        col_cnt <= '0;
        row_cnt <= (row_cnt == ROW_MAX) ? '0 : row_cnt + 1'b1;
      end else begin
        col_cnt <= col_cnt + 1'b1;
      end
    end
  end

  assign pos_ok   = (row_cnt >= ROW_MIN) && (col_cnt >= COL_MIN);
  assign pos_last = (row_cnt == ROW_MAX) && (col_cnt == COL_MAX);
endmodule

// File: rtl/cv_coef_bank.sv
module cv_coef_bank #(
  parameter int NK     = 10,
  parameter int TAPS   = 49,
  parameter int COEF_W = 8,
  parameter int BIAS_W = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  we,
  input  logic [conv_pkg::idx_w(NK)-1:0]        kern,
  input  logic [conv_pkg::idx_w(TAPS+1)-1:0]    tap,
  input  logic [BIAS_W-1:0]                     wdata,
  output logic [NK-1:0][TAPS-1:0][COEF_W-1:0]   coef,
  output logic [NK-1:0][BIAS_W-1:0]             bias
);
  localparam int KW = conv_pkg::idx_w(NK);
  localparam int TW = conv_pkg::idx_w(TAPS + 1);

  genvar gn, gt;
  generate
    for (gn = 0; gn < NK; gn++) begin : g_kern
      for (gt = 0; gt < TAPS; gt++) begin : g_tap
        always_ff @(posedge clk) begin
          if (!rst_n) coef[gn][gt] <= '0;
          else if (we && kern == KW'(gn) && tap == TW'(gt))
            coef[gn][gt] <= wdata[COEF_W-1:0];
        end
      end
      always_ff @(posedge clk) begin
        if (!rst_n) bias[gn] <= '0;
        else if (we && kern == KW'(gn) && tap == TW'(TAPS))
          bias[gn] <= wdata;
      end
    end
  endgenerate
endmodule

// File: rtl/cv_mac_relu.sv
module cv_mac_relu #(
  parameter int DATA_W  = 8,
  parameter int COEF_W  = 8,
  parameter int BIAS_W  = 16,
  parameter int TAPS    = 49,
  parameter int OUT_W   = 8,
  parameter int FRAC_SH = 6
) (
  input  logic [TAPS-1:0][DATA_W-1:0] win,
  input  logic [TAPS-1:0][COEF_W-1:0] coef,
  input  logic [BIAS_W-1:0]           bias,
  output logic [OUT_W-1:0]            res
);
  localparam int ACC_W  = conv_pkg::acc_w(DATA_W, COEF_W, BIAS_W, TAPS);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (OUT_W - 1)) - 1);

  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  scaled;
  logic signed [PROD_W-1:0] xa, xb, pr;

  always_comb begin
    acc = ACC_W'($signed(bias));
    xa = '0;
    xb = '0;
    pr = '0;
    for (int t = 0; t < TAPS; t++) begin
      xa  = PROD_W'($signed(win[t]));
      xb  = PROD_W'($signed(coef[t]));
      pr  = xa * xb;
      acc = acc + ACC_W'(pr);
    end
    scaled = acc >>> FRAC_SH;
    if (acc[ACC_W-1])       res = '0;
    else if (scaled > MAXV) res = MAXV[OUT_W-1:0];
    else                    res = scaled[OUT_W-1:0];
  end
endmodule

// File: rtl/stream_conv_engine.sv
module stream_conv_engine import conv_pkg::*; #(
  parameter int DATA_W  = 8,
  parameter int COEF_W  = 8,
  parameter int BIAS_W  = 16,
  parameter int OUT_W   = 8,
  parameter int FRAC_SH = 6,
  parameter int IMG_W   = 28,
  parameter int IMG_H   = 28,
  parameter int KS      = 7,
  parameter int NK      = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [DATA_W-1:0]             in_pixel,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [NK*OUT_W-1:0]           out_data,
  output logic                          out_last,
  input  logic                          cfg_we,
  input  logic [idx_w(NK)-1:0]          cfg_kern,
  input  logic [idx_w(KS*KS+1)-1:0]     cfg_tap,
  input  logic [BIAS_W-1:0]             cfg_data
);
  localparam int TAPS = KS * KS;

  logic advance, take;
  logic pos_ok, pos_last;
  logic s1_valid, s1_last;
  logic [TAPS-1:0][DATA_W-1:0]          win;
  logic [NK-1:0][TAPS-1:0][COEF_W-1:0]  coef;
  logic [NK-1:0][BIAS_W-1:0]            bias;
  logic [NK-1:0][OUT_W-1:0]             lane;

  // Whole pipe moves together; it stops only when an output is refused.
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;
  assign take     = in_valid && advance;

  cv_window #(.DATA_W(DATA_W), .IMG_W(IMG_W), .IMG_H(IMG_H), .KS(KS)) win_i (
    .clk(clk), .rst_n(rst_n), .step(take), .pix(in_pixel),
    .win(win), .pos_ok(pos_ok), .pos_last(pos_last)
  );

  cv_coef_bank #(.NK(NK), .TAPS(TAPS), .COEF_W(COEF_W), .BIAS_W(BIAS_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .kern(cfg_kern), .tap(cfg_tap),
    .wdata(cfg_data), .coef(coef), .bias(bias)
  );

  genvar gn;
  generate
    for (gn = 0; gn < NK; gn++) begin : g_mac
      cv_mac_relu #(
        .DATA_W(DATA_W), .COEF_W(COEF_W), .BIAS_W(BIAS_W),
        .TAPS(TAPS), .OUT_W(OUT_W), .FRAC_SH(FRAC_SH)
      ) mac_i (
        .win(win), .coef(coef[gn]), .bias(bias[gn]), .res(lane[gn])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_last   <= 1'b0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else if (advance) begin
      s1_valid  <= take && pos_ok;
      s1_last   <= take && pos_last;
      out_valid <= s1_valid;
      out_last  <= s1_valid && s1_last;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   out_data <= '0;
    else if (advance && s1_valid) out_data <= lane;
  end
endmodule

// File: rtl/stream_conv_engine_chk.sv
module stream_conv_engine_chk #(
  parameter int NK    = 10,
  parameter int OUT_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [NK*OUT_W-1:0]   out_data,
  input logic                  out_last
);
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);                                  // R9
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data) && $stable(out_last));     // R9
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);                                  // R10
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);                                                // R10
  AST_LAST_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);                                                 // R8

  genvar gn;
  generate
    for (gn = 0; gn < NK; gn++) begin : g_lane
      AST_LANE_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_data[gn*OUT_W + OUT_W - 1]);                      // R5
    end
  endgenerate
endmodule

bind stream_conv_engine stream_conv_engine_chk #(.NK(NK), .OUT_W(OUT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
);

// File: tb/stream_conv_engine_tb_top.sv
module stream_conv_engine_tb_top;
  localparam int DW = 4, CW = 4, BW = 12, OW = 8, SH = 2;
  localparam int IW = 12, IH = 10, KSZ = 7, NKB = 4;
  localparam int TAPS = KSZ * KSZ;
  localparam int KWB = conv_pkg::idx_w(NKB);
  localparam int TWB = conv_pkg::idx_w(TAPS + 1);
  localparam int OUT_PER_FRAME = (IH - KSZ + 1) * (IW - KSZ + 1);
  localparam int MAXO = (1 << (OW - 1)) - 1;
  localparam int NFRAMES = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [DW-1:0] in_pixel = '0;
  logic out_valid, out_last;
  logic out_ready = 1'b0;
  logic [NKB*OW-1:0] out_data;
  logic cfg_we = 1'b0;
  logic [KWB-1:0] cfg_kern = '0;
  logic [TWB-1:0] cfg_tap = '0;
  logic [BW-1:0] cfg_data = '0;

  always #2 clk = ~clk;  // 250 MHz

  stream_conv_engine #(
    .DATA_W(DW), .COEF_W(CW), .BIAS_W(BW), .OUT_W(OW), .FRAC_SH(SH),
    .IMG_W(IW), .IMG_H(IH), .KS(KSZ), .NK(NKB)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pixel(in_pixel), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .cfg_we(cfg_we),
    .cfg_kern(cfg_kern), .cfg_tap(cfg_tap), .cfg_data(cfg_data)
  );

  int total = 0, bad = 0;
  int img [IH][IW];
  int wt [NKB][TAPS+1];
  logic [NKB*OW:0] exp_q [$];
  string tag_q [$];
  int rdy_pct = 100;
  int popped = 0, lasts_seen = 0;
  bit drv_done = 1'b0;
  bit first_checked = 1'b0;
  bit prev_stall = 1'b0;
  logic [NKB*OW-1:0] prev_data;
  logic prev_last;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int model(input int n, input int y, input int x);
    int acc;
    acc = wt[n][TAPS];                                   // R3 bias
    for (int j = 0; j < KSZ; j++)
      for (int k = 0; k < KSZ; k++)
        acc += img[y+j][x+k] * wt[n][j*KSZ + k];         // R3 tap order
    if (acc < 0) return 0;                               // R5
    acc = acc >>> SH;                                    // R4
    if (acc > MAXO) acc = MAXO;                          // R6
    return acc;
  endfunction

  task automatic push_expected(input string tag);
    for (int y = 0; y <= IH - KSZ; y++)
      for (int x = 0; x <= IW - KSZ; x++) begin
        logic [NKB*OW:0] v;
        v = '0;
        for (int n = 0; n < NKB; n++) v[n*OW +: OW] = OW'(model(n, y, x));  // R7 lane layout
        v[NKB*OW] = (y == IH - KSZ) && (x == IW - KSZ);                     // R8
        exp_q.push_back(v);
        tag_q.push_back(tag);
      end
  endtask

  task automatic load_weights();
    for (int n = 0; n < NKB; n++)
      for (int t = 0; t <= TAPS; t++) begin
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_kern = KWB'(n);
        cfg_tap = TWB'(t);
        cfg_data = BW'(wt[n][t]);
      end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive_frame(input int vpct, input string tag);
    int idx;
    push_expected(tag);
    drv_done = 1'b0;
    idx = 0;
    while (idx < IW * IH) begin
      @(negedge clk);
      if ($urandom_range(99) < vpct) begin
        in_valid = 1'b1;
        in_pixel = DW'(img[idx / IW][idx % IW]);
        #1;
        if (in_ready) idx++;
      end else begin
        in_valid = 1'b0;
      end
    end
    drv_done = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rand_image(input int lo, input int hi);
    for (int y = 0; y < IH; y++)
      for (int x = 0; x < IW; x++) img[y][x] = lo + int'($urandom_range(hi - lo));
  endtask

  task automatic rand_weights();
    for (int n = 0; n < NKB; n++) begin
      for (int t = 0; t < TAPS; t++) wt[n][t] = int'($urandom_range(15)) - 8;
      wt[n][TAPS] = int'($urandom_range(600)) - 300;
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Monitor: decides ready, then compares any output that will transfer at the next edge.
  always @(negedge clk) begin
    out_ready = ($urandom_range(99) < rdy_pct);
    #1;
    if (rst_n) begin
      if (prev_stall)  // R9 held output
        check(out_valid && out_data == prev_data && out_last == prev_last, "R9",
              {31'd0, out_valid, out_data}, {31'd1, 1'b1, prev_data});
      if (out_valid && !out_ready)  // R10 input refused while output waits
        check(!in_ready, "R10", 64'(in_ready), 64'd0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected output", 64'(out_data), 64'd0);
        end else begin
          logic [NKB*OW:0] e;
          string tg;
          e = exp_q.pop_front();
          tg = tag_q.pop_front();
          if (!first_checked) begin  // R12 early start
            first_checked = 1'b1;
            check(!drv_done, "R12", 64'(drv_done), 64'd0);
          end
          check(out_data == e[NKB*OW-1:0], tg, 64'(out_data), 64'(e[NKB*OW-1:0]));
          check(out_last == e[NKB*OW], "R8", 64'(out_last), 64'(e[NKB*OW]));
          popped++;
          if (out_last) lasts_seen++;
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data = out_data;
      prev_last = out_last;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 64'(popped), 64'(NFRAMES * OUT_PER_FRAME));
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);

    // Frame A: random data, no bubbles, no stall.
    rand_weights();
    load_weights();
    rand_image(-8, 7);
    rdy_pct = 100;
    drive_frame(100, "R3 R4 frame A");

    // Frame B back-to-back: counters must wrap; bubbles and stalls (R11).
    rand_image(-8, 7);
    rdy_pct = 55;
    drive_frame(65, "R11 frame B");
    drain();

    // Frame C: lane 0 saturates (R6), lane 1 always negative (R5).
    rand_weights();
    for (int t = 0; t < TAPS; t++) begin
      wt[0][t] = 7;
      wt[1][t] = -8;
    end
    wt[0][TAPS] = 2047;
    wt[1][TAPS] = -1;
    load_weights();
    rand_image(0, 7);
    rdy_pct = 80;
    drive_frame(90, "R5 R6 frame C");
    drain();

    // Frame D: fresh weights, heavy back-pressure and sparse input (R11).
    rand_weights();
    load_weights();
    rand_image(-8, 7);
    rdy_pct = 30;
    drive_frame(45, "R11 frame D");
    drain();

    check(popped == NFRAMES * OUT_PER_FRAME, "R2 count", 64'(popped), 64'(NFRAMES * OUT_PER_FRAME));
    check(lasts_seen == NFRAMES, "R8 frames", 64'(lasts_seen), 64'(NFRAMES));
    finish_run();
  end
endmodule